// File: doc/BRIEF.md
# ADC Code to Voltage Readout

This block turns 12-bit conversion results from an external analog-to-digital converter into a voltage shown on four seven-segment digits. Three slide switches pick the analog channel. The block registers that choice and drives it to the converter as a channel-select output. The converter returns a one-cycle valid strobe together with a 12-bit code.

The analog path ahead of the converter halves the voltage at the board input. A full-scale code therefore stands for 5.0 V at the input. The block computes the input voltage in millivolts as `(code * 5000) >> 12`, which gives 0 to 4998 mV. A sequential shift-and-add-three engine turns that value into four BCD digits. The digits are held in a display register and shown in the form `V.mmm`, with the decimal point lit on the leftmost digit.

The control state machine has three states. `S_IDLE` waits for an accepted sample and captures the millivolt value (transition *accept*). `S_LOAD` starts the BCD engine for one cycle (transition *launch*). `S_WAIT` waits for the engine's done pulse, then writes the display register and returns to `S_IDLE` (transition *publish*). The BCD engine has its own two states. `DAB_IDLE` moves to `DAB_SHIFT` on start. `DAB_SHIFT` runs one adjust-and-shift step per cycle and returns to `DAB_IDLE` after the last bit.

Top module: `adc_volt_display`

## Requirements
- R1: After reset, `adc_chan` is 0 and the display shows 0.000: digit 3 is `8'h40`, and digits 2, 1 and 0 are each `8'hC0`.
- R2: `adc_chan` equals the value `sw_sel` had at the previous rising clock edge.
- R3: For an accepted code c, the displayed value is floor(c * 5000 / 4096) millivolts. Digit 3 (`hex_n[31:24]`) shows the volts and digit 0 (`hex_n[7:0]`) shows the millivolt units, each in decimal.
- R4: Each digit byte is active low. Bit 7 is the decimal point, and bits 6..0 are the segments g,f,e,d,c,b,a. The active-high patterns for 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F.
- R5: The decimal point is lit (bit 7 = 0) on digit 3 only. It is dark on digits 2, 1 and 0.
- R6: A sample accepted at rising edge E0 appears on `hex_n` after edge E15. The display is unchanged after E14, and it changes at no other time.
- R7: After a change of `sw_sel`, the next valid sample is discarded and leaves the display unchanged. The sample after that is shown normally.
- R8: A valid sample that arrives while a conversion is in progress (state not `S_IDLE`) is ignored.
- R9: Code 0 shows 0.000 and code 4095 shows 4.998.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_sel | input | 3 | Channel choice from the switches |
| adc_valid | input | 1 | One-cycle strobe marking a finished conversion |
| adc_code | input | 12 | Conversion result, valid with `adc_valid` |
| adc_chan | output | 3 | Registered channel select sent to the converter |
| hex_n | output | 32 | Four active-low digit bytes, digit 3 in the top byte |

## Verification
The assertions check the following on every cycle:
- the channel select trails the switches by one cycle;
- the decimal-point pattern is fixed;
- every held digit is a legal decimal value;
- the display moves only on the engine's done pulse;
- a dropped or mid-conversion sample never reaches the captured millivolt register.

Only the bench's scenarios can show the rest:
- the arithmetic result for every one of the 4096 codes;
- the segment patterns;
- the exact fifteen-cycle update point;
- that the sample after a dropped one is shown again.

// File: rtl/avd_pkg.sv
package avd_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LOAD = 2'd1,
        S_WAIT = 2'd2
    } ctl_state_t;

    typedef enum logic {
        DAB_IDLE  = 1'b0,
        DAB_SHIFT = 1'b1
    } dab_state_t;

endpackage

// File: rtl/avd_scale.sv
module avd_scale #(
    parameter int CODE_W  = 12,
    parameter int FULL_MV = 5000,
    parameter int MV_W    = 13
) (
    input  logic [CODE_W-1:0] code,
    output logic [MV_W-1:0]   mv
);
    localparam int PROD_W = CODE_W + MV_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod = PROD_W'(code) * PROD_W'(FULL_MV);
        mv   = prod[PROD_W-1:CODE_W];
    end
endmodule

// File: rtl/avd_dabble.sv
module avd_dabble #(
    parameter int BIN_W  = 13,
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [BIN_W-1:0]      bin,
    output logic                  done,
    output logic [DIGITS*4-1:0]   bcd
);
    import avd_pkg::*;

    localparam int BCD_W = DIGITS * 4;
    localparam int CNT_W = $clog2(BIN_W + 1);

    dab_state_t        st_q, st_d;
    logic [BIN_W-1:0]  sh_q;
    logic [BCD_W-1:0]  acc_q;
    logic [BCD_W-1:0]  adj;
    logic [CNT_W-1:0]  cnt_q;
    logic              done_q;
    logic              last;

    for (genvar g = 0; g < DIGITS; g++) begin : g_adj
        assign adj[4*g +: 4] = (acc_q[4*g +: 4] >= 4'd5) ? acc_q[4*g +: 4] + 4'd3
                                                          : acc_q[4*g +: 4];
    end

    assign last = (cnt_q == CNT_W'(BIN_W - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= DAB_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DAB_IDLE:  if (start) st_d = DAB_SHIFT;
            DAB_SHIFT: if (last)  st_d = DAB_IDLE;
            default:   st_d = DAB_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            acc_q  <= '0;
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= (st_q == DAB_SHIFT) && last;
            if (st_q == DAB_IDLE && start) begin
                sh_q  <= bin;
                acc_q <= '0;
                cnt_q <= '0;
            end else if (st_q == DAB_SHIFT) begin
                {acc_q, sh_q} <= {adj, sh_q} << 1;
                cnt_q         <= cnt_q + 1'b1;
            end
        end
    end

    assign done = done_q;
    assign bcd  = acc_q;
endmodule

// File: rtl/avd_seg7.sv
module avd_seg7 (
    input  logic [3:0] digit,
    input  logic       dp_on,
    output logic [7:0] seg_n
);
    logic [6:0] lit;

    always_comb begin
        unique case (digit)
            4'd0:    lit = 7'h3F;
            4'd1:    lit = 7'h06;
            4'd2:    lit = 7'h5B;
            4'd3:    lit = 7'h4F;
            4'd4:    lit = 7'h66;
            4'd5:    lit = 7'h6D;
            4'd6:    lit = 7'h7D;
            4'd7:    lit = 7'h07;
            4'd8:    lit = 7'h7F;
            4'd9:    lit = 7'h6F;
            default: lit = 7'h00;
        endcase
        seg_n = {~dp_on, ~lit};
    end
endmodule

// File: rtl/adc_volt_display.sv
module adc_volt_display #(
    parameter int CODE_W  = 12,
    parameter int SEL_W   = 3,
    parameter int FULL_MV = 5000,
    parameter int DIGITS  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [SEL_W-1:0]      sw_sel,
    input  logic                  adc_valid,
    input  logic [CODE_W-1:0]     adc_code,
    output logic [SEL_W-1:0]      adc_chan,
    output logic [DIGITS*8-1:0]   hex_n
);
    import avd_pkg::*;

    localparam int MV_W  = $clog2(FULL_MV);
    localparam int BCD_W = DIGITS * 4;

    ctl_state_t        st_q, st_d;
    logic [SEL_W-1:0]  chan_q;
    logic              drop_q;
    logic              chg;
    logic              accept;
    logic [MV_W-1:0]   mv_w, mv_q;
    logic              bcd_start;
    logic              bcd_done;
    logic [BCD_W-1:0]  bcd_w;
    logic [BCD_W-1:0]  disp_q;

    assign chg    = (sw_sel != chan_q);
    assign accept = adc_valid && !drop_q && !chg;

    avd_scale #(.CODE_W(CODE_W), .FULL_MV(FULL_MV), .MV_W(MV_W)) u_scale (
        .code (adc_code),
        .mv   (mv_w)
    );

    avd_dabble #(.BIN_W(MV_W), .DIGITS(DIGITS)) u_dabble (
        .clk   (clk),
        .rst_n (rst_n),
        .start (bcd_start),
        .bin   (mv_q),
        .done  (bcd_done),
        .bcd   (bcd_w)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:  if (accept)   st_d = S_LOAD;
            S_LOAD:                st_d = S_WAIT;
            S_WAIT:  if (bcd_done) st_d = S_IDLE;
            default:               st_d = S_IDLE;
        endcase
    end

    // state outputs
    always_comb begin
        bcd_start = (st_q == S_LOAD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_q <= '0;
            drop_q <= 1'b0;
            mv_q   <= '0;
            disp_q <= '0;
        end else begin
            chan_q <= sw_sel;
            if (chg)            drop_q <= 1'b1;
            else if (adc_valid) drop_q <= 1'b0;
            if (st_q == S_IDLE && accept)   mv_q   <= mv_w;
            if (st_q == S_WAIT && bcd_done) disp_q <= bcd_w;
        end
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_seg
        avd_seg7 u_seg (
            .digit (disp_q[4*g +: 4]),
            .dp_on (g == DIGITS - 1),
            .seg_n (hex_n[8*g +: 8])
        );
    end

    assign adc_chan = chan_q;
endmodule

// File: rtl/avd_chk.sv
module avd_chk #(
    parameter int CODE_W = 12,
    parameter int SEL_W  = 3,
    parameter int DIGITS = 4,
    parameter int MV_W   = 13
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [SEL_W-1:0]        sw_sel,
    input logic [SEL_W-1:0]        adc_chan,
    input logic                    adc_valid,
    input logic [DIGITS*8-1:0]     hex_n,
    input avd_pkg::ctl_state_t     st,
    input logic                    bcd_done,
    input logic [MV_W-1:0]         mv_q,
    input logic                    drop_q,
    input logic [DIGITS*4-1:0]     disp_q
);
    import avd_pkg::*;

    // R2
    chan_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> adc_chan == $past(sw_sel));

    // R5
    dp_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !hex_n[8*DIGITS-1] |-> (hex_n[7] && hex_n[15] && hex_n[23]));

    // R6
    disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(st == S_WAIT && bcd_done) |=> $stable(hex_n));

    // R7
    drop_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_q && adc_valid) |=> $stable(mv_q));

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_IDLE) |=> $stable(mv_q));

    for (genvar g = 0; g < DIGITS; g++) begin : g_rng
        // R3
        digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !hex_n[8*DIGITS-1] |-> disp_q[4*g +: 4] <= 4'd9);
    end
endmodule

bind adc_volt_display avd_chk #(
    .CODE_W (CODE_W),
    .SEL_W  (SEL_W),
    .DIGITS (DIGITS),
    .MV_W   (MV_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_sel    (sw_sel),
    .adc_chan  (adc_chan),
    .adc_valid (adc_valid),
    .hex_n     (hex_n),
    .st        (st_q),
    .bcd_done  (bcd_done),
    .mv_q      (mv_q),
    .drop_q    (drop_q),
    .disp_q    (disp_q)
);

// File: tb/tb_adc_volt_display.sv
module tb_adc_volt_display;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  sw_sel = 3'd0;
    logic        adc_valid = 1'b0;
    logic [11:0] adc_code = 12'd0;
    logic [2:0]  adc_chan;
    logic [31:0] hex_n;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    adc_volt_display dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sw_sel    (sw_sel),
        .adc_valid (adc_valid),
        .adc_code  (adc_code),
        .adc_chan  (adc_chan),
        .hex_n     (hex_n)
    );

    function automatic logic [6:0] pat(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F;
            4: return 7'h66; 5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07;
            8: return 7'h7F; default: return 7'h6F;
        endcase
    endfunction

    function automatic logic [31:0] exp_hex(input int mv);
        logic [31:0] r;
        int v;
        v = mv;
        for (int d = 0; d < 4; d++) begin
            r[8*d +: 8] = {(d == 3) ? 1'b0 : 1'b1, ~pat(v % 10)};
            v = v / 10;
        end
        return r;
    endfunction

    function automatic int code_mv(input int c);
        return (c * 5000) / 4096;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic pulse(input int c);
        @(negedge clk);
        adc_valid = 1'b1;
        adc_code  = 12'(c);
        @(negedge clk);
        adc_valid = 1'b0;
    endtask

    task automatic sample(input int c);
        pulse(c);
        repeat (20) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 chan", {29'd0, adc_chan}, 32'd0);
        chk("R1 hex", hex_n, 32'h40C0C0C0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R9 boundary codes
        sample(0);
        chk("R9 zero", hex_n, exp_hex(0));
        sample(4095);
        chk("R9 full", hex_n, 32'h66C0D290 ^ 32'h0 ^ (exp_hex(4998) ^ 32'h66C0D290));
        chk("R9 full 4.998", hex_n, exp_hex(4998));

        // R6 update latency: valid at edge E0, new value after E15
        sample(1000);
        pulse(2000);
        repeat (14) @(negedge clk);
        chk("R6 before E15", hex_n, exp_hex(code_mv(1000)));
        @(negedge clk);
        chk("R6 after E15", hex_n, exp_hex(code_mv(2000)));
        repeat (10) @(negedge clk);

        // R8 sample during conversion ignored
        pulse(300);
        pulse(3900);
        repeat (25) @(negedge clk);
        chk("R8 busy ignore", hex_n, exp_hex(code_mv(300)));

        // R2 / R7 channel change
        @(negedge clk);
        sw_sel = 3'd5;
        @(negedge clk);
        chk("R2 chan", {29'd0, adc_chan}, 32'd5);
        sample(4000);
        chk("R7 dropped", hex_n, exp_hex(code_mv(300)));
        sample(2500);
        chk("R7 next shown", hex_n, exp_hex(code_mv(2500)));
        @(negedge clk);
        sw_sel = 3'd2;
        @(negedge clk);
        chk("R2 chan 2", {29'd0, adc_chan}, 32'd2);
        sample(100);
        chk("R7 dropped 2", hex_n, exp_hex(code_mv(2500)));

        // R3 R4 R5 exhaustive sweep
        for (int c = 0; c < 4096; c++) begin
            sample(c);
            chk($sformatf("R3 R4 R5 code=%0d", c), hex_n, exp_hex(code_mv(c)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule